// File: doc/BRIEF.md
# File-Output Command Bridge

This block is a memory-mapped bus slave that lets a soft processor produce file output on a host or monitor. Software selects a file handle, sends a file name one character per write, sets an open mode, and pushes content bytes. The block turns these register writes into a stream of command records on a valid/ready output. There are three kinds of record: open, close and write-byte. Each record carries the handle that is active at the time.

File names are collected in an internal buffer. A zero written as a name character ends the name and issues an open record. That record carries the handle, the stored mode and the name length. While the open record is presented, the consumer reads the buffered characters through an index port. The buffer empties once the open record has been taken.

The block holds only one command record at a time. While a record waits for its consumer, bus accesses are not acknowledged. This stalls the processor, so no command can be lost.

Top module: `file_cmd_bridge`

## Requirements
- R1: After reset, `busAck` and `cmdValid` are low, and both the handle register and the mode register read back as zero.
- R2: Every bus access is acknowledged by `busAck` high for exactly one cycle, in the cycle after `busCyc` and `busStb` are sampled high. Word addresses 4 to 7 are acknowledged, read as zero and change nothing.
- R3: Word address 0 (handle) and word address 3 (mode) read back their stored values, zero-extended. Word address 1 (name) and word address 2 (content) read as zero, and a read never issues a command.
- R4: A write to word address 2 issues one write-byte record. It has kind 2, carries the selected handle, and carries data bits 7:0 on `cmdData`.
- R5: A write to word address 0 stores data bits 7:0 as the handle and issues no command. Later write-byte records carry the new handle.
- R6: A nonzero write to word address 1 appends data bits 7:0 to the name buffer. A zero write issues an open record. It has kind 0 and carries the handle, the stored mode and the name length. During that record, `nameIdx` = i returns character i on `nameChar`.
- R7: A write to word address 3 stores data bits 2:0 as the mode. Any value other than 1 issues no command. The next open record carries the stored mode.
- R8: Writing mode 1 issues a close record. It has kind 1, carries the current handle, and has `cmdMode` equal to 1.
- R9: Name characters beyond `NAME_DEPTH` are dropped, and a sticky overflow flag is set. The open record reports the flag on `cmdNameOvf` with length `NAME_DEPTH`. When an open record is accepted, the length and the flag are cleared.
- R10: While `cmdValid` is high and `cmdReady` is low, the record fields stay stable and no bus access is acknowledged. A stalled access completes, and is acknowledged, in the cycle after the record is accepted.
- R11: A write with `busSel[0]` low is acknowledged but changes no register and issues no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busCyc | input | 1 | Bus cycle active |
| busStb | input | 1 | Bus strobe |
| busWe | input | 1 | Write enable |
| busAddr | input | 3 | Word address |
| busSel | input | 4 | Byte lane select |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid with busAck |
| busAck | output | 1 | Access acknowledge |
| cmdValid | output | 1 | Command record valid |
| cmdReady | input | 1 | Consumer accepts the record |
| cmdKind | output | 2 | 0 open, 1 close, 2 write-byte |
| cmdHandle | output | HANDLE_W | Handle tagged on the record |
| cmdMode | output | 3 | Mode code |
| cmdData | output | 8 | Content byte for write-byte records |
| cmdNameLen | output | clog2(NAME_DEPTH+1) | Name length for open records |
| cmdNameOvf | output | 1 | Name overflowed |
| nameIdx | input | clog2(NAME_DEPTH) | Name character index |
| nameChar | output | 8 | Buffered name character, zero past the length |

## Verification
A handle register that is wrong shows up on the very next write-byte, open or close record, and on a read of word address 0 one cycle after the strobe. If the name length or the overflow flag is not cleared, the following open record reports the wrong length or a stale flag, so checks run two opens back to back. Missing backpressure shows up as an acknowledge while a record is pending, or as record fields that change before acceptance. A bad byte-lane or address decode shows up as a register that changed when it should not have, or as an unexpected record.

// File: rtl/file_cmd_pkg.sv
package file_cmd_pkg;
  localparam logic [1:0] CMD_OPEN  = 2'd0;
  localparam logic [1:0] CMD_CLOSE = 2'd1;
  localparam logic [1:0] CMD_BYTE  = 2'd2;

  localparam logic [2:0] MODE_CLOSE = 3'd1;

  localparam logic [1:0] REG_HANDLE = 2'd0;
  localparam logic [1:0] REG_NAME   = 2'd1;
  localparam logic [1:0] REG_DATA   = 2'd2;
  localparam logic [1:0] REG_MODE   = 2'd3;

  typedef struct packed {
    logic       rd;
    logic       rdMapped;
    logic [1:0] rdSel;
    logic       wrHandle;
    logic       wrName;
    logic       wrData;
    logic       wrMode;
  } strobe_t;
endpackage

// File: rtl/file_cmd_ctrl.sv
module file_cmd_ctrl
  import file_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       busCyc,
  input  logic       busStb,
  input  logic       busWe,
  input  logic [2:0] busAddr,
  input  logic [3:0] busSel,
  input  logic       cmdBusy,
  output logic       busAck,
  output strobe_t    strobes
);
  logic accept;
  logic mapped;
  logic wrEn;
  logic unusedSel;

  assign unusedSel = ^busSel[3:1];
  assign accept = busCyc && busStb && !busAck && !cmdBusy;
  assign mapped = !busAddr[2];
  assign wrEn   = accept && busWe && busSel[0] && mapped;

  always_comb begin
    strobes          = '0;
    strobes.rd       = accept && !busWe;
    strobes.rdMapped = mapped;
    strobes.rdSel    = busAddr[1:0];
    strobes.wrHandle = wrEn && (busAddr[1:0] == REG_HANDLE);
    strobes.wrName   = wrEn && (busAddr[1:0] == REG_NAME);
    strobes.wrData   = wrEn && (busAddr[1:0] == REG_DATA);
    strobes.wrMode   = wrEn && (busAddr[1:0] == REG_MODE);
  end

  always_ff @(posedge clk) begin
    if (rst) busAck <= 1'b0;
    else     busAck <= accept;
  end

  assert_ack_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    busAck |=> !busAck);
  assert_ack_has_req_R2: assert property (@(posedge clk) disable iff (rst)
    busAck |-> $past(busCyc && busStb));
  assert_no_ack_busy_R10: assert property (@(posedge clk) disable iff (rst)
    busAck |-> !$past(cmdBusy));
endmodule

// File: rtl/file_cmd_datapath.sv
module file_cmd_datapath
  import file_cmd_pkg::*;
#(
  parameter int NAME_DEPTH = 255,
  parameter int HANDLE_W   = 8,
  localparam int LEN_W     = $clog2(NAME_DEPTH + 1),
  localparam int IDX_W     = $clog2(NAME_DEPTH)
) (
  input  logic                clk,
  input  logic                rst,
  input  strobe_t             strobes,
  input  logic [31:0]         wdata,
  output logic [31:0]         rdata,
  output logic                cmdValid,
  input  logic                cmdReady,
  output logic [1:0]          cmdKind,
  output logic [HANDLE_W-1:0] cmdHandle,
  output logic [2:0]          cmdMode,
  output logic [7:0]          cmdData,
  output logic [LEN_W-1:0]    cmdNameLen,
  output logic                cmdNameOvf,
  input  logic [IDX_W-1:0]    nameIdx,
  output logic [7:0]          nameChar
);
  logic [HANDLE_W-1:0] handleReg;
  logic [2:0]          modeReg;
  logic [7:0]          nameMem [NAME_DEPTH];
  logic [LEN_W-1:0]    nameLen;
  logic                nameOvf;
  logic [7:0]          charIn;
  logic                charPush;
  logic                nameEnd;
  logic                bufFull;
  logic                unusedWdata;

  assign unusedWdata = ^wdata[31:8];
  assign charIn   = wdata[7:0];
  assign bufFull  = (nameLen >= LEN_W'(NAME_DEPTH));
  assign charPush = strobes.wrName && (charIn != 8'd0);
  assign nameEnd  = strobes.wrName && (charIn == 8'd0);

  always_ff @(posedge clk) begin
    if (charPush && !bufFull) nameMem[nameLen[IDX_W-1:0]] <= charIn;
  end

  assign nameChar = (LEN_W'(nameIdx) < nameLen) ? nameMem[nameIdx] : 8'd0;

  always_ff @(posedge clk) begin
    if (rst) begin
      handleReg  <= '0;
      modeReg    <= '0;
      nameLen    <= '0;
      nameOvf    <= 1'b0;
      rdata      <= '0;
      cmdValid   <= 1'b0;
      cmdKind    <= CMD_OPEN;
      cmdHandle  <= '0;
      cmdMode    <= '0;
      cmdData    <= '0;
      cmdNameLen <= '0;
      cmdNameOvf <= 1'b0;
    end else begin
      if (cmdValid && cmdReady) begin
        cmdValid <= 1'b0;
        if (cmdKind == CMD_OPEN) begin
          nameLen <= '0;
          nameOvf <= 1'b0;
        end
      end
      if (strobes.rd) begin
        rdata <= '0;
        if (strobes.rdMapped && strobes.rdSel == REG_HANDLE) rdata <= 32'(handleReg);
        if (strobes.rdMapped && strobes.rdSel == REG_MODE)   rdata <= 32'(modeReg);
      end
      if (strobes.wrHandle) handleReg <= wdata[HANDLE_W-1:0];
      if (charPush) begin
        if (bufFull) nameOvf <= 1'b1;
        else         nameLen <= nameLen + 1'b1;
      end
      if (nameEnd) begin
        cmdValid   <= 1'b1;
        cmdKind    <= CMD_OPEN;
        cmdHandle  <= handleReg;
        cmdMode    <= modeReg;
        cmdData    <= 8'd0;
        cmdNameLen <= nameLen;
        cmdNameOvf <= nameOvf;
      end
      if (strobes.wrData) begin
        cmdValid   <= 1'b1;
        cmdKind    <= CMD_BYTE;
        cmdHandle  <= handleReg;
        cmdMode    <= modeReg;
        cmdData    <= wdata[7:0];
        cmdNameLen <= '0;
        cmdNameOvf <= 1'b0;
      end
      if (strobes.wrMode) begin
        modeReg <= wdata[2:0];
        if (wdata[2:0] == MODE_CLOSE) begin
          cmdValid   <= 1'b1;
          cmdKind    <= CMD_CLOSE;
          cmdHandle  <= handleReg;
          cmdMode    <= MODE_CLOSE;
          cmdData    <= 8'd0;
          cmdNameLen <= '0;
          cmdNameOvf <= 1'b0;
        end
      end
    end
  end

  assert_cmd_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (cmdValid && !cmdReady) |=> (cmdValid && $stable(cmdKind) && $stable(cmdHandle)
                                 && $stable(cmdData) && $stable(cmdMode)));
  assert_name_bound_R9: assert property (@(posedge clk) disable iff (rst)
    nameLen <= LEN_W'(NAME_DEPTH));
  assert_buf_cleared_R9: assert property (@(posedge clk) disable iff (rst)
    (cmdValid && cmdReady && cmdKind == CMD_OPEN) |=> (nameLen == '0 && !nameOvf));
endmodule

// File: rtl/file_cmd_bridge.sv
module file_cmd_bridge
  import file_cmd_pkg::*;
#(
  parameter int NAME_DEPTH = 255,
  parameter int HANDLE_W   = 8,
  localparam int LEN_W     = $clog2(NAME_DEPTH + 1),
  localparam int IDX_W     = $clog2(NAME_DEPTH)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                busCyc,
  input  logic                busStb,
  input  logic                busWe,
  input  logic [2:0]          busAddr,
  input  logic [3:0]          busSel,
  input  logic [31:0]         busWdata,
  output logic [31:0]         busRdata,
  output logic                busAck,
  output logic                cmdValid,
  input  logic                cmdReady,
  output logic [1:0]          cmdKind,
  output logic [HANDLE_W-1:0] cmdHandle,
  output logic [2:0]          cmdMode,
  output logic [7:0]          cmdData,
  output logic [LEN_W-1:0]    cmdNameLen,
  output logic                cmdNameOvf,
  input  logic [IDX_W-1:0]    nameIdx,
  output logic [7:0]          nameChar
);
  strobe_t strobes;

  file_cmd_ctrl ctrl_i (
    .clk(clk), .rst(rst), .busCyc(busCyc), .busStb(busStb), .busWe(busWe),
    .busAddr(busAddr), .busSel(busSel), .cmdBusy(cmdValid),
    .busAck(busAck), .strobes(strobes)
  );

  file_cmd_datapath #(.NAME_DEPTH(NAME_DEPTH), .HANDLE_W(HANDLE_W)) dp_i (
    .clk(clk), .rst(rst), .strobes(strobes), .wdata(busWdata), .rdata(busRdata),
    .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdKind(cmdKind),
    .cmdHandle(cmdHandle), .cmdMode(cmdMode), .cmdData(cmdData),
    .cmdNameLen(cmdNameLen), .cmdNameOvf(cmdNameOvf),
    .nameIdx(nameIdx), .nameChar(nameChar)
  );
endmodule

// File: tb/file_cmd_bridge_tb.sv
module file_cmd_bridge_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int LEN_W = $clog2(DEPTH + 1);
  localparam int IDX_W = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic busCyc = 0, busStb = 0, busWe = 0;
  logic [2:0] busAddr = '0;
  logic [3:0] busSel = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic busAck, cmdValid, cmdNameOvf;
  logic cmdReady = 1'b0;
  logic [1:0] cmdKind;
  logic [7:0] cmdHandle, cmdData, nameChar;
  logic [2:0] cmdMode;
  logic [LEN_W-1:0] cmdNameLen;
  logic [IDX_W-1:0] nameIdx = '0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  file_cmd_bridge #(.NAME_DEPTH(DEPTH), .HANDLE_W(8)) dut_i (
    .clk(clk), .rst(rst), .busCyc(busCyc), .busStb(busStb), .busWe(busWe),
    .busAddr(busAddr), .busSel(busSel), .busWdata(busWdata), .busRdata(busRdata),
    .busAck(busAck), .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdKind(cmdKind),
    .cmdHandle(cmdHandle), .cmdMode(cmdMode), .cmdData(cmdData),
    .cmdNameLen(cmdNameLen), .cmdNameOvf(cmdNameOvf), .nameIdx(nameIdx), .nameChar(nameChar)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 20000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [2:0] addr, input logic we, input logic [31:0] data,
                      input logic [3:0] sel, output logic [31:0] rd);
    int waitN = 0;
    @(negedge clk);
    busCyc = 1; busStb = 1; busWe = we; busAddr = addr; busWdata = data; busSel = sel;
    do begin
      @(negedge clk);
      waitN++;
    end while (!busAck && waitN < 100);
    rd = busRdata;
    busCyc = 0; busStb = 0; busWe = 0;
    @(negedge clk);
    chk("R2 ack single cycle", {31'd0, busAck}, 32'd0);
  endtask

  task automatic wr(input logic [2:0] addr, input logic [31:0] data);
    logic [31:0] d;
    xfer(addr, 1'b1, data, 4'hF, d);
  endtask

  task automatic rdReg(input logic [2:0] addr, output logic [31:0] d);
    xfer(addr, 1'b0, 32'd0, 4'hF, d);
  endtask

  task automatic expectCmd(input string req, input logic [1:0] kind, input logic [7:0] h,
                           input logic [2:0] mode, input logic [7:0] data,
                           input int len, input logic ovf);
    chk({req, " valid"}, {31'd0, cmdValid}, 32'd1);
    chk({req, " kind"}, {30'd0, cmdKind}, {30'd0, kind});
    chk({req, " handle"}, {24'd0, cmdHandle}, {24'd0, h});
    chk({req, " mode"}, {29'd0, cmdMode}, {29'd0, mode});
    chk({req, " data"}, {24'd0, cmdData}, {24'd0, data});
    chk({req, " len"}, 32'(cmdNameLen), 32'(len));
    chk({req, " ovf"}, {31'd0, cmdNameOvf}, {31'd0, ovf});
  endtask

  task automatic take;
    cmdReady = 1;
    @(negedge clk);
    cmdReady = 0;
    chk("R10 record taken", {31'd0, cmdValid}, 32'd0);
  endtask

  task automatic expectNone(input string req);
    chk(req, {31'd0, cmdValid}, 32'd0);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 ack low", {31'd0, busAck}, 32'd0);
    chk("R1 valid low", {31'd0, cmdValid}, 32'd0);
    rdReg(3'd0, d); chk("R1 handle zero", d, 32'd0);
    rdReg(3'd3, d); chk("R1 mode zero", d, 32'd0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(3'd0, 32'h0000_0103);
    expectNone("R5 handle write no cmd");
    rdReg(3'd0, d); chk("R3 handle readback", d, 32'h03);
    wr(3'd3, 32'd2);
    expectNone("R7 mode 2 no cmd");
    rdReg(3'd3, d); chk("R3 mode readback", d, 32'd2);
    rdReg(3'd1, d); chk("R3 name reads zero", d, 32'd0);
    rdReg(3'd2, d); chk("R3 content reads zero", d, 32'd0);
    expectNone("R3 read issues no cmd");
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    wr(3'd4, 32'h55);
    expectNone("R2 unmapped write no cmd");
    rdReg(3'd6, d); chk("R2 unmapped reads zero", d, 32'd0);
    rdReg(3'd0, d); chk("R2 handle untouched", d, 32'h03);
  endtask

  task automatic t_bytes;
    wr(3'd2, 32'h0000_01A5);
    expectCmd("R4 byte", 2'd2, 8'd3, 3'd2, 8'hA5, 0, 1'b0);
    take();
    wr(3'd0, 32'd7);
    expectNone("R5 select no cmd");
    wr(3'd2, 32'h42);
    expectCmd("R5 byte new handle", 2'd2, 8'd7, 3'd2, 8'h42, 0, 1'b0);
    take();
  endtask

  task automatic t_open;
    wr(3'd3, 32'd4);
    wr(3'd1, "a"); wr(3'd1, "b"); wr(3'd1, "c");
    expectNone("R6 chars no cmd");
    wr(3'd1, 32'd0);
    expectCmd("R6 R7 open", 2'd0, 8'd7, 3'd4, 8'd0, 3, 1'b0);
    nameIdx = 0; #1 chk("R6 char0", {24'd0, nameChar}, "a");
    nameIdx = 2; #1 chk("R6 char2", {24'd0, nameChar}, "c");
    nameIdx = 3; #1 chk("R6 past len zero", {24'd0, nameChar}, 32'd0);
    take();
  endtask

  task automatic t_close;
    wr(3'd3, 32'd1);
    expectCmd("R8 close", 2'd1, 8'd7, 3'd1, 8'd0, 0, 1'b0);
    take();
  endtask

  task automatic t_overflow;
    wr(3'd3, 32'd3);
    for (int i = 0; i < DEPTH + 2; i++) wr(3'd1, 32'h41 + i);
    wr(3'd1, 32'd0);
    expectCmd("R9 overflow open", 2'd0, 8'd7, 3'd3, 8'd0, DEPTH, 1'b1);
    nameIdx = IDX_W'(DEPTH - 1); #1
    chk("R9 last kept char", {24'd0, nameChar}, 32'h41 + DEPTH - 1);
    take();
    wr(3'd1, "z"); wr(3'd1, 32'd0);
    expectCmd("R9 cleared after open", 2'd0, 8'd7, 3'd3, 8'd0, 1, 1'b0);
    nameIdx = 0; #1 chk("R9 new char0", {24'd0, nameChar}, "z");
    take();
  endtask

  task automatic t_sel;
    logic [31:0] d;
    xfer(3'd0, 1'b1, 32'd9, 4'hE, d);
    rdReg(3'd0, d); chk("R11 handle unchanged", d, 32'd7);
    xfer(3'd2, 1'b1, 32'h66, 4'h0, d);
    expectNone("R11 content no cmd");
  endtask

  task automatic t_backpressure;
    int waitN = 0;
    wr(3'd2, 32'h11);
    @(negedge clk);
    busCyc = 1; busStb = 1; busWe = 1; busAddr = 3'd2; busWdata = 32'h22; busSel = 4'hF;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R10 no ack while pending", {31'd0, busAck}, 32'd0);
      chk("R10 data held", {24'd0, cmdData}, 32'h11);
    end
    cmdReady = 1;
    @(negedge clk);
    cmdReady = 0;
    while (!busAck && waitN < 10) begin
      @(negedge clk);
      waitN++;
    end
    chk("R10 ack after accept", {31'd0, busAck}, 32'd1);
    chk("R10 ack next cycle", 32'(waitN), 32'd1);
    busCyc = 0; busStb = 0; busWe = 0;
    expectCmd("R10 stalled byte", 2'd2, 8'd7, 3'd3, 8'h22, 0, 1'b0);
    take();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_unmapped();
    t_bytes();
    t_open();
    t_close();
    t_overflow();
    t_sel();
    t_backpressure();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule